// File: doc/BRIEF.md
# PLL Frequency Ramp Controller

This block brings a PLL up to a high output frequency in controlled stages instead of one jump. On a start pulse it works out the output frequency that the final settings would give on the CPU clock branch and on the interconnect clock branch fed by this PLL. From that it decides whether a ramp is needed. If one is needed, it writes a feedback numerator that matches a safe threshold frequency. It then raises the numerator in fixed frequency steps, and it finishes by writing the final numerator. The denominator stays at its final value in every word, because changing it would disturb jitter.

Each write is a single configuration word with a one-cycle strobe. The block then waits for the PLL lock input before it computes or issues the next word. The lock wait has a programmable cycle limit. If lock does not come back within that limit, the sequence aborts and an error flag is raised. All products and quotients are formed by one shared shift-and-add / restoring-divide unit that takes one bit per cycle. Frequencies are plain integers in MHz.

Top module: `pll_ramp_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy, done, err and cfg_wr are 0 and cfg_word is 0.
- R2: When neither branch needs a ramp, the block issues exactly one write, the final word (den in bits [16 +: DEN_W], final_numer in bits [15:0]), waits for lock and completes.
- R3: The CPU branch ramps when cpu_sel is 1 and its target is strictly above 900 MHz. The ramp then starts at 900 MHz and steps by CPU_STEP_MHZ (50), using cpu_pre and cpu_post. The CPU branch is tested before the interconnect branch.
- R4: When the CPU branch does not ramp, the interconnect branch ramps if noc_sel is 1 and its target is strictly above 300 MHz. The ramp then starts at 300 MHz and steps by NOC_STEP_MHZ (25), using noc_pre and noc_post.
- R5: A branch target is ((ref_mhz / (den+1)) * (final_numer+1)) / ((pre+1) * (post+1)), truncating each division. A target exactly equal to its threshold does not ramp.
- R6: Every word carries den in bits [16 +: DEN_W] and a numerator in bits [15:0]. For a step frequency F the numerator is the low 16 bits of (F / ref_mhz) * (pre+1) * (post+1) * (den+1) - 1.
- R7: A ramp writes the threshold numerator first, then one numerator for each F = threshold + k*step (k >= 1) while F < target, and then the final word, in that order.
- R8: After a strobe, no further strobe is issued until lock has been seen high.
- R9: If lock stays low for more than lock_limit cycles of a wait, the run ends with err = 1, busy = 0, no done pulse and no further writes. err clears on the next start.
- R10: busy is 1 from the cycle after an accepted start. done is a single-cycle pulse after lock follows the final write, and busy is 0 during that pulse.
- R11: A start pulse while busy is ignored, so the write sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a ramp decision and sequence |
| lock | input | 1 | PLL lock indication |
| ref_mhz | input | FREQ_W | Reference frequency in MHz, nonzero |
| den | input | DEN_W | Feedback denominator register value |
| final_numer | input | NUM_W | Final feedback numerator register value |
| cpu_sel | input | 1 | CPU clock branch is sourced from this PLL |
| cpu_pre | input | DIV_W | CPU branch counter inside the PLL group |
| cpu_post | input | DIV_W | CPU branch external divider count |
| noc_sel | input | 1 | Interconnect clock branch is sourced from this PLL |
| noc_pre | input | DIV_W | Interconnect branch counter inside the PLL group |
| noc_post | input | DIV_W | Interconnect branch external divider count |
| lock_limit | input | TMO_W | Maximum cycles to wait for lock after a write |
| cfg_word | output | WORD_W | Denominator and numerator word |
| cfg_wr | output | 1 | One-cycle write strobe for cfg_word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock timeout, held until next start |

## Verification
The assertions assume that the configuration inputs (ref_mhz, den, final_numer, the selects and divider counts) stay constant from start to the end of a run. They also assume that the PLL drops lock on the edge that takes a strobe and raises it again some cycles later. The bench sets up each configuration at a falling edge before it pulses start and does not touch it until done or err. Its PLL model clears lock when it sees cfg_wr and re-raises it after a per-run delay, or never re-raises it in the timeout case. The sweep covers both selects, two denominators and numerators that land below, exactly on and above each threshold.

// File: rtl/ramp_pkg.sv
// Shared types for the PLL ramp controller.
package ramp_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_SEL, ST_T1, ST_T2, ST_T3, ST_TGT, ST_CMP,
        ST_K, ST_Q, ST_N, ST_WRITE, ST_LOCK, ST_DONE
    } ramp_state_e;

    typedef enum logic {OP_MUL, OP_DIV} arith_op_e;
endpackage

// File: rtl/ramp_arith.sv
// Sequential arithmetic unit: unsigned multiply (shift-add) or divide
// (restoring), one result bit per cycle, W cycles per operation.
// Assumes go is only raised while idle and b is nonzero for a divide.
module ramp_arith import ramp_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  arith_op_e    op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         rdy
);
    localparam int CW = $clog2(W) + 1;

    logic          run;
    logic [CW-1:0] cnt;
    logic [W-1:0]  acc, opa, opb;
    arith_op_e     op_q;
    logic [W:0]    shl, diff;

    // Trial subtraction for one restoring-divide step.
    always_comb begin
        shl  = {acc, opa[W-1]};
        diff = shl - {1'b0, opb};
    end

    // Operation sequencer and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0; rdy <= 1'b0; cnt <= '0;
            acc <= '0; opa <= '0; opb <= '0; op_q <= OP_MUL;
        end else begin
            rdy <= 1'b0;
            if (go && !run) begin
                run <= 1'b1; cnt <= '0; acc <= '0;
                opa <= a; opb <= b; op_q <= op;
            end else if (run) begin
                if (op_q == OP_MUL) begin
                    if (opb[0]) acc <= acc + opa;
                    opa <= opa << 1;
                    opb <= opb >> 1;
                end else if (shl >= {1'b0, opb}) begin
                    acc <= diff[W-1:0];
                    opa <= {opa[W-2:0], 1'b1};
                end else begin
                    acc <= shl[W-1:0];
                    opa <= {opa[W-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CW'(W - 1)) begin
                    run <= 1'b0;
                    rdy <= 1'b1;
                end
            end
        end
    end

    assign res = (op_q == OP_MUL) ? acc : opa;

    // R5
    arith_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !run);
    // R6
    arith_rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);
endmodule

// File: rtl/ramp_lock_wait.sv
// Lock wait timer: counts cycles while armed, reports lock seen or the
// limit passed. Assumes arm drops for at least one cycle between waits.
module ramp_lock_wait #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          lock,
    input  logic [TW-1:0] limit,
    output logic          seen,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Count armed cycles, saturating; cleared whenever not armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end

    assign seen    = arm && lock;
    assign expired = arm && !lock && (cnt >= limit);

    // R9
    wait_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arm) |-> (cnt == '0));
endmodule

// File: rtl/pll_ramp_ctrl.sv
// PLL frequency ramp controller. Decides whether the CPU or interconnect
// branch requires a ramp, then writes numerator steps with a lock wait
// after each. Assumes configuration inputs are stable during a run and
// that lock falls on the edge that takes a strobe.
module pll_ramp_ctrl import ramp_pkg::*; #(
    parameter int FREQ_W       = 16,
    parameter int DEN_W        = 6,
    parameter int NUM_W        = 16,
    parameter int DIV_W        = 8,
    parameter int WORD_W       = 32,
    parameter int TMO_W        = 16,
    parameter int ARITH_W      = 32,
    parameter int CPU_THR_MHZ  = 900,
    parameter int NOC_THR_MHZ  = 300,
    parameter int CPU_STEP_MHZ = 50,
    parameter int NOC_STEP_MHZ = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lock,
    input  logic [FREQ_W-1:0] ref_mhz,
    input  logic [DEN_W-1:0]  den,
    input  logic [NUM_W-1:0]  final_numer,
    input  logic              cpu_sel,
    input  logic [DIV_W-1:0]  cpu_pre,
    input  logic [DIV_W-1:0]  cpu_post,
    input  logic              noc_sel,
    input  logic [DIV_W-1:0]  noc_pre,
    input  logic [DIV_W-1:0]  noc_post,
    input  logic [TMO_W-1:0]  lock_limit,
    output logic [WORD_W-1:0] cfg_word,
    output logic              cfg_wr,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int PAD_W = WORD_W - NUM_W - DEN_W;

    ramp_state_e        state;
    logic               src_noc, last, issued;
    logic [ARITH_W-1:0] t_reg, t3, k, tgt_f, cur_f, step_f;
    logic [ARITH_W-1:0] op_a, op_b, res, thr_sel, nf;
    logic [DIV_W-1:0]   sel_pre, sel_post;
    logic               op_go, rdy, seen, expired, arith_st, cur_sel;
    arith_op_e          op_sel;

    // Branch-dependent divider counts, threshold and selection.
    always_comb begin
        sel_pre  = src_noc ? noc_pre  : cpu_pre;
        sel_post = src_noc ? noc_post : cpu_post;
        thr_sel  = src_noc ? ARITH_W'(NOC_THR_MHZ) : ARITH_W'(CPU_THR_MHZ);
        cur_sel  = src_noc ? noc_sel : cpu_sel;
        nf       = cur_f + step_f;
    end

    // Operand routing to the shared arithmetic unit per state.
    always_comb begin
        op_sel = OP_MUL; op_a = '0; op_b = ARITH_W'(1); arith_st = 1'b1;
        case (state)
            ST_T1:  begin op_sel = OP_DIV; op_a = ARITH_W'(ref_mhz);
                          op_b = ARITH_W'(den) + 1'b1; end
            ST_T2:  begin op_a = t_reg; op_b = ARITH_W'(final_numer) + 1'b1; end
            ST_T3:  begin op_a = ARITH_W'(sel_pre) + 1'b1;
                          op_b = ARITH_W'(sel_post) + 1'b1; end
            ST_TGT: begin op_sel = OP_DIV; op_a = t_reg; op_b = t3; end
            ST_K:   begin op_a = t3; op_b = ARITH_W'(den) + 1'b1; end
            ST_Q:   begin op_sel = OP_DIV; op_a = cur_f; op_b = ARITH_W'(ref_mhz); end
            ST_N:   begin op_a = t_reg; op_b = k; end
            default: arith_st = 1'b0;
        endcase
        op_go = arith_st && !issued;
    end

    ramp_arith #(.W(ARITH_W)) u_arith (
        .clk(clk), .rst_n(rst_n), .go(op_go), .op(op_sel),
        .a(op_a), .b(op_b), .res(res), .rdy(rdy)
    );

    ramp_lock_wait #(.TW(TMO_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .arm(state == ST_LOCK), .lock(lock),
        .limit(lock_limit), .seen(seen), .expired(expired)
    );

    // Main sequence: decision, step numerators, writes and lock waits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; src_noc <= 1'b0; last <= 1'b0; issued <= 1'b0;
            t_reg <= '0; t3 <= '0; k <= '0; tgt_f <= '0; cur_f <= '0;
            step_f <= '0; cfg_word <= '0; err <= 1'b0;
        end else begin
            if (op_go) issued <= 1'b1;
            if (rdy)   issued <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state <= ST_SEL; src_noc <= 1'b0; last <= 1'b0; err <= 1'b0;
                end
                ST_SEL: if (cur_sel) state <= ST_T1;
                    else if (!src_noc) src_noc <= 1'b1;
                    else begin
                        last <= 1'b1; state <= ST_WRITE;
                        cfg_word <= {{PAD_W{1'b0}}, den, final_numer};
                    end
                ST_T1:  if (rdy) begin t_reg <= res; state <= ST_T2; end
                ST_T2:  if (rdy) begin t_reg <= res; state <= ST_T3; end
                ST_T3:  if (rdy) begin t3 <= res; state <= ST_TGT; end
                ST_TGT: if (rdy) begin tgt_f <= res; state <= ST_CMP; end
                ST_CMP: if (tgt_f > thr_sel) begin
                        cur_f <= thr_sel; state <= ST_K;
                        step_f <= src_noc ? ARITH_W'(NOC_STEP_MHZ) : ARITH_W'(CPU_STEP_MHZ);
                    end else if (!src_noc) begin
                        src_noc <= 1'b1; state <= ST_SEL;
                    end else begin
                        last <= 1'b1; state <= ST_WRITE;
                        cfg_word <= {{PAD_W{1'b0}}, den, final_numer};
                    end
                ST_K:   if (rdy) begin k <= res; state <= ST_Q; end
                ST_Q:   if (rdy) begin t_reg <= res; state <= ST_N; end
                ST_N:   if (rdy) begin
                        cfg_word <= {{PAD_W{1'b0}}, den, NUM_W'(res - 1'b1)};
                        state <= ST_WRITE;
                    end
                ST_WRITE: state <= ST_LOCK;
                ST_LOCK: if (expired) begin
                        err <= 1'b1; state <= ST_IDLE;
                    end else if (seen) begin
                        if (last) state <= ST_DONE;
                        else if (nf < tgt_f) begin cur_f <= nf; state <= ST_Q; end
                        else begin
                            last <= 1'b1; state <= ST_WRITE;
                            cfg_word <= {{PAD_W{1'b0}}, den, final_numer};
                        end
                    end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cfg_wr = (state == ST_WRITE);
    assign done   = (state == ST_DONE);
    assign busy   = (state != ST_IDLE) && (state != ST_DONE);

    // R8
    no_wr_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK && !lock) |=> !cfg_wr);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    done_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(lock));
    // R6
    den_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> (cfg_word[NUM_W +: DEN_W] == den));
    // R9
    err_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !cfg_wr && !done));
    // R11
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_LOCK && state != ST_SEL && state != ST_CMP) |=> busy);
endmodule

// File: tb/pll_ramp_ctrl_bench.sv
module pll_ramp_ctrl_bench;
    logic clk = 0, rst_n = 0, start = 0, lock;
    logic [15:0] ref_mhz = 16'd25, final_numer = '0, lock_limit = 16'd200;
    logic [5:0]  den = '0;
    logic        cpu_sel = 0, noc_sel = 0;
    logic [7:0]  cpu_pre = 8'd0, cpu_post = 8'd0, noc_pre = 8'd1, noc_post = 8'd1;
    logic [31:0] cfg_word;
    logic        cfg_wr, busy, done, err;

    int total = 0, fails = 0, cyc = 0;
    int ngot = 0, nexp = 0, dly = 3;
    logic [31:0] got [0:63];
    logic [31:0] expw [0:63];
    bit pend = 0, dead = 0, plock = 1;
    int lcnt = 0;

    always #10 clk = ~clk;
    assign lock = plock;

    pll_ramp_ctrl u_pll_ramp_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .lock(lock), .ref_mhz(ref_mhz),
        .den(den), .final_numer(final_numer), .cpu_sel(cpu_sel), .cpu_pre(cpu_pre),
        .cpu_post(cpu_post), .noc_sel(noc_sel), .noc_pre(noc_pre), .noc_post(noc_post),
        .lock_limit(lock_limit), .cfg_word(cfg_word), .cfg_wr(cfg_wr), .busy(busy),
        .done(done), .err(err)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // PLL model: lock falls when a write is taken, returns after dly cycles.
    always @(posedge clk) begin
        if (!rst_n) begin plock <= 1; lcnt <= 0; end
        else if (cfg_wr) begin plock <= 0; lcnt <= dly; end
        else if (!plock && !dead) begin
            if (lcnt <= 1) plock <= 1; else lcnt <= lcnt - 1;
        end
    end

    // Write monitor and lock handshake check.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_wr) begin
                check(!pend, "R8 write before lock", pend, 0);
                pend = 1;
                if (ngot < 64) got[ngot] = cfg_word;
                ngot++;
            end else if (lock) pend = 0;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++; total++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic int unsigned tgt_of(int unsigned d, int unsigned fn,
                                           int unsigned pr, int unsigned po);
        return ((ref_mhz / (d + 1)) * (fn + 1)) / ((pr + 1) * (po + 1));
    endfunction

    function automatic logic [31:0] word_of(int unsigned n);
        return {10'd0, den, n[15:0]};
    endfunction

    // Build expected write list; returns path 0 none, 1 cpu, 2 noc; bnd on threshold hit.
    task automatic build(output int path, output bit bnd);
        int unsigned tc, tn, thr, stp, fin, kk;
        tc = tgt_of(den, final_numer, cpu_pre, cpu_post);
        tn = tgt_of(den, final_numer, noc_pre, noc_post);
        bnd = (cpu_sel && tc == 900) || (noc_sel && tn == 300);
        path = 0; nexp = 0;
        if (cpu_sel && tc > 900) begin
            path = 1; thr = 900; stp = 50; fin = tc;
            kk = (cpu_pre + 1) * (cpu_post + 1) * (den + 1);
        end else if (noc_sel && tn > 300) begin
            path = 2; thr = 300; stp = 25; fin = tn;
            kk = (noc_pre + 1) * (noc_post + 1) * (den + 1);
        end
        if (path != 0) begin
            expw[nexp++] = word_of((thr / ref_mhz) * kk - 1);
            for (int unsigned f = thr + stp; f < fin; f += stp)
                expw[nexp++] = word_of((f / ref_mhz) * kk - 1);
        end
        expw[nexp++] = word_of(final_numer);
    endtask

    task automatic run_case(input bit restart);
        int path; bit bnd; string tag;
        build(path, bnd);
        tag = bnd ? "R5 threshold" : (path == 1 ? "R3 cpu" : (path == 2 ? "R4 noc" : "R2 none"));
        ngot = 0;
        start = 1; @(negedge clk); start = 0;
        check(busy == 1, "R10 busy after start", busy, 1);
        check(err == 0, "R9 err cleared", err, 0);
        for (int n = 0; n < 20000; n++) begin
            if (restart && n == 30) start = 1;
            if (restart && n == 31) start = 0;
            if (done || err) break;
            @(negedge clk);
        end
        check(done == 1, "R10 done", done, 1);
        check(busy == 0, "R10 busy low at done", busy, 0);
        @(negedge clk);
        check(done == 0, "R10 done single", done, 0);
        check(ngot == nexp, {tag, " write count"}, ngot, nexp);
        for (int i = 0; i < nexp && i < ngot; i++) begin
            check(got[i] == expw[i], restart ? "R11 sequence" : "R7 sequence", got[i], expw[i]);
            check(got[i][21:16] == den, "R6 den field", got[i][21:16], den);
        end
    endtask

    initial begin
        int nums [5] = '{35, 36, 47, 63, 79};
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0, "R1 flags", {busy, done, err}, 0);
        check(cfg_wr == 0 && cfg_word == 0, "R1 word", cfg_word, 0);
        rst_n = 1; @(negedge clk);
        for (int cs = 0; cs < 2; cs++)
            for (int ns = 0; ns < 2; ns++)
                for (int ni = 0; ni < 5; ni++)
                    for (int d = 0; d < 2; d++) begin
                        cpu_sel = cs[0]; noc_sel = ns[0];
                        final_numer = 16'(nums[ni]); den = 6'(d);
                        dly = 1 + ((cs + ns + ni + d) % 4);
                        run_case(0);
                    end
        // Restarted start during a long cpu ramp must change nothing.
        cpu_sel = 1; noc_sel = 0; final_numer = 16'd79; den = 0;
        run_case(1);
        // Lock never returns: timeout.
        dead = 1; cpu_sel = 0; noc_sel = 0; lock_limit = 16'd20; ngot = 0;
        begin
            bit saw_done = 0;
            start = 1; @(negedge clk); start = 0;
            for (int n = 0; n < 200; n++) begin
                if (done) saw_done = 1;
                if (err) break;
                @(negedge clk);
            end
            check(err == 1, "R9 err raised", err, 1);
            check(busy == 0, "R9 busy low", busy, 0);
            check(saw_done == 0, "R9 no done", saw_done, 0);
            repeat (20) @(negedge clk);
            check(ngot == 1, "R9 no further writes", ngot, 1);
            check(got[0] == word_of(16'd79), "R9 single final word", got[0], word_of(16'd79));
        end
        dead = 0; lock_limit = 16'd200;
        noc_sel = 1; final_numer = 16'd63;
        run_case(0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule